// File: doc/BRIEF.md
# Handshaked Parallel Port Controller

This block is an 8-bit bidirectional parallel port that sits beside a small CPU bus. The CPU sees two registers, selected by `cpuSel`. Select 0 is the port data register. Select 1 is the control/status word. On the far side, an external device uses an active-low input strobe to hand a byte to the CPU. It uses an active-low output strobe to collect the byte the CPU has left for it. Two flags follow the two transfers: "input full" and "output full".

Two auxiliary flag pins are configured by fields of the control word. Each pin can drive a constant, show one of the two flags, or act as a control input. As an input, pin A chooses whether the port drives the data buffer or the control/status word. As an input, pin B gates both strobes. All external strobe and flag inputs pass through two-flop synchronizers before any edge detection. A change on a pin therefore takes effect in the register state two clock edges after it is first sampled. The pad drivers are outside the block: it only gives the data to drive and a drive enable.

Top module: `hsParPort`

## Requirements
- R1: After reset, both buffers, both flags and all control bits are 0. `flagAOut`/`flagBOut` are 0 with their enables 1, and `pinOe` is 0.
- R2: The status word read at select 1 is {ctrl[7:2], outFull, inFull}. A CPU write at select 1 updates bits 7:2 only. Bits 1:0 always show the flags and cannot be written.
- R3: A CPU write at select 0 loads the output buffer and sets outFull (status bit 1). A CPU read at select 0 returns the input buffer and clears inFull (status bit 0).
- R4: With status bit 2 = 0 (edge mode), a falling edge of `inStbN` captures `pinIn` and sets inFull. Pin changes while the strobe stays low are not captured.
- R5: With status bit 2 = 1 (level mode), the input buffer follows `pinIn` while `inStbN` is low and holds its last value after `inStbN` goes high. inFull is set.
- R6: Status bit 3 selects the edge of `outStbN` that clears outFull: 1 selects the rising edge, 0 the falling edge. The other edge leaves outFull unchanged.
- R7: Bits 5:4 set pin A. 00 drives 0, 01 drives 1 and 10 drives outFull, each with `flagAOe` = 1. 11 makes the pin an input, with `flagAOe` = 0.
- R8: When bits 5:4 = 11, `flagAIn` high makes `pinOut` carry the status word and `flagAIn` low makes it carry the output buffer. In every other pin-A mode, `pinOut` carries the output buffer.
- R9: Bits 7:6 set pin B. 00 drives 0, 01 drives 1 and 10 drives inFull, each with `flagBOe` = 1. 11 makes the pin an input, with `flagBOe` = 0.
- R10: When bits 7:6 = 11 and `flagBIn` is high, both strobes are ignored: no capture, no inFull set, no outFull clear, and `pinOe` stays 0. With `flagBIn` low, transfers work normally.
- R11: `pinOe` is 1 only while the synchronized `outStbN` is low and the port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 1 | Register select: 0 data, 1 control/status |
| cpuWr | input | 1 | CPU write pulse |
| cpuRd | input | 1 | CPU read pulse (side effect on data register) |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data (combinational) |
| pinIn | input | 8 | Port pins as seen from the pads |
| pinOut | output | 8 | Data to drive on the port pins |
| pinOe | output | 1 | Port drive enable |
| inStbN | input | 1 | Active-low input strobe |
| outStbN | input | 1 | Active-low output strobe |
| flagAIn | input | 1 | Flag pin A input value |
| flagAOut | output | 1 | Flag pin A output value |
| flagAOe | output | 1 | Flag pin A drive enable |
| flagBIn | input | 1 | Flag pin B input value |
| flagBOut | output | 1 | Flag pin B output value |
| flagBOe | output | 1 | Flag pin B drive enable |

## Verification
A random phase mixes data and control writes and reads, with every pin-mode code. After each step it compares the read data, the flags, both flag pins and `pinOut` against a bench model. This separates the register-file and output-mux behaviour from the strobe logic. Directed strobe sequences do the rest. An input strobe that stays low while the pins change tells edge capture from level following. Driving the output strobe low and then high, under each clear-edge setting, shows which edge clears outFull. Repeating those transfers with pin B high, and then low, in port-enable mode shows that the gate blocks both directions and releases them again.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  typedef enum logic [1:0] {
    PIN_LOW  = 2'b00,
    PIN_HIGH = 2'b01,
    PIN_FLAG = 2'b10,
    PIN_IN   = 2'b11
  } pinMode_e;

  typedef struct packed {
    logic ldOut;
    logic ldCtrl;
    logic capIn;
    logic clrIbf;
    logic clrObf;
  } hppStrobes_t;
endpackage

// File: rtl/hpp_sync.sv
module hpp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else if (s == 0) stage[s] <= din;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/hpp_control.sv
module hpp_control
  import hpp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuSel,
  input  logic        cpuWr,
  input  logic        cpuRd,
  input  logic        inStbN,
  input  logic        outStbN,
  input  logic        flagAIn,
  input  logic        flagBIn,
  input  logic [5:0]  ctrl,
  output hppStrobes_t stb,
  output logic        aSelCsr,
  output logic        pinOe
);
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] SYNC_RST = 4'b0011;

  logic [NSIG-1:0] syncd;
  logic inNow, outNow, aNow, bNow;
  logic inPrev, outPrev;
  logic levelMode, obfOnRise, portEn;
  pinMode_e aMode, bMode;

  hpp_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({flagBIn, flagAIn, outStbN, inStbN}),
    .dout(syncd)
  );

  assign {bNow, aNow, outNow, inNow} = syncd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPrev  <= 1'b1;
      outPrev <= 1'b1;
    end else begin
      inPrev  <= inNow;
      outPrev <= outNow;
    end
  end

  assign levelMode = ctrl[0];
  assign obfOnRise = ctrl[1];
  assign aMode     = pinMode_e'(ctrl[3:2]);
  assign bMode     = pinMode_e'(ctrl[5:4]);
  assign portEn    = !(bMode == PIN_IN && bNow);

  always_comb begin
    stb.ldOut  = cpuWr && !cpuSel;
    stb.ldCtrl = cpuWr && cpuSel;
    stb.clrIbf = cpuRd && !cpuSel;
    stb.capIn  = portEn && (levelMode ? !inNow : (inPrev && !inNow));
    stb.clrObf = portEn && (obfOnRise ? (!outPrev && outNow)
                                      : (outPrev && !outNow));
  end

  assign aSelCsr = (aMode == PIN_IN) && aNow;
  assign pinOe   = portEn && !outNow;
endmodule

// File: rtl/hpp_datapath.sv
module hpp_datapath
  import hpp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  hppStrobes_t   stb,
  input  logic [DW-1:0] cpuWdata,
  input  logic [DW-1:0] pinIn,
  output logic [DW-1:0] inBuf,
  output logic [DW-1:0] outBuf,
  output logic [DW-3:0] ctrl,
  output logic          ibf,
  output logic          obf
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBuf  <= '0;
      outBuf <= '0;
      ctrl   <= '0;
      ibf    <= 1'b0;
      obf    <= 1'b0;
    end else begin
      if (stb.ldOut)  outBuf <= cpuWdata;
      if (stb.ldCtrl) ctrl   <= cpuWdata[DW-1:2];
      if (stb.capIn)  inBuf  <= pinIn;
      if (stb.capIn)       ibf <= 1'b1;
      else if (stb.clrIbf) ibf <= 1'b0;
      if (stb.ldOut)       obf <= 1'b1;
      else if (stb.clrObf) obf <= 1'b0;
    end
  end
endmodule

// File: rtl/hsParPort.sv
module hsParPort
  import hpp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuSel,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic [7:0] cpuWdata,
  output logic [7:0] cpuRdata,
  input  logic [7:0] pinIn,
  output logic [7:0] pinOut,
  output logic       pinOe,
  input  logic       inStbN,
  input  logic       outStbN,
  input  logic       flagAIn,
  output logic       flagAOut,
  output logic       flagAOe,
  input  logic       flagBIn,
  output logic       flagBOut,
  output logic       flagBOe
);
  localparam int DW = 8;

  hppStrobes_t stb;
  logic [DW-1:0] inBuf, outBuf, csrWord;
  logic [DW-3:0] ctrl;
  logic ibf, obf, aSelCsr;
  pinMode_e aMode, bMode;

  hpp_control #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .inStbN(inStbN), .outStbN(outStbN), .flagAIn(flagAIn), .flagBIn(flagBIn),
    .ctrl(ctrl), .stb(stb), .aSelCsr(aSelCsr), .pinOe(pinOe)
  );

  hpp_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWdata(cpuWdata), .pinIn(pinIn),
    .inBuf(inBuf), .outBuf(outBuf), .ctrl(ctrl), .ibf(ibf), .obf(obf)
  );

  assign csrWord  = {ctrl, obf, ibf};
  assign cpuRdata = cpuSel ? csrWord : inBuf;
  assign pinOut   = aSelCsr ? csrWord : outBuf;
  assign aMode    = pinMode_e'(ctrl[3:2]);
  assign bMode    = pinMode_e'(ctrl[5:4]);

  always_comb begin
    flagAOe = (aMode != PIN_IN);
    unique case (aMode)
      PIN_HIGH: flagAOut = 1'b1;
      PIN_FLAG: flagAOut = obf;
      default:  flagAOut = 1'b0;
    endcase
    flagBOe = (bMode != PIN_IN);
    unique case (bMode)
      PIN_HIGH: flagBOut = 1'b1;
      PIN_FLAG: flagBOut = ibf;
      default:  flagBOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/hsParPort_chk.sv
module hsParPort_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuSel,
  input logic       cpuWr,
  input logic       outStbN,
  input logic       pinOe,
  input logic       obf,
  input logic       ibf,
  input logic [7:0] cpuRdata,
  input logic       flagAOut,
  input logic       flagBOut
);
  logic [1:0] modeA, modeB;
  assign modeA = cpuSel ? cpuRdata[5:4] : 2'b00;
  assign modeB = cpuSel ? cpuRdata[7:6] : 2'b00;

  // R3
  wr_sets_obf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !cpuSel) |=> obf);

  // R6
  obf_fall_no_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(obf) |-> !$past(cpuWr && !cpuSel));

  // R11
  oe_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinOe |-> !$past(outStbN, 2));

  // R7
  flag_a_obf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && modeA == 2'b10) |-> (flagAOut == obf));

  // R9
  flag_b_ibf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && modeB == 2'b10) |-> (flagBOut == ibf));

  // R2
  status_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuSel |-> (cpuRdata[1:0] == {obf, ibf}));
endmodule

bind hsParPort hsParPort_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .outStbN(outStbN),
  .pinOe(pinOe), .obf(obf), .ibf(ibf), .cpuRdata(cpuRdata),
  .flagAOut(flagAOut), .flagBOut(flagBOut)
);

// File: tb/hsParPort_test.sv
`timescale 1ns/1ps
module hsParPort_test;
  logic clk = 0, rstN = 0;
  logic cpuSel = 0, cpuWr = 0, cpuRd = 0;
  logic [7:0] cpuWdata = 0, pinIn = 0;
  logic inStbN = 1, outStbN = 1, flagAIn = 0, flagBIn = 0;
  wire [7:0] cpuRdata, pinOut;
  wire pinOe, flagAOut, flagAOe, flagBOut, flagBOe;

  int nChk = 0, nBad = 0;
  bit done = 0;
  logic [5:0] mCtrl = 0;
  logic [7:0] mOut = 0, mIn = 0;
  logic mIbf = 0, mObf = 0;

  always #5 clk = ~clk;

  hsParPort uut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mCsr();
    return {mCtrl, mObf, mIbf};
  endfunction

  function automatic logic flagVal(logic [1:0] m, logic f);
    return (m == 2'b01) ? 1'b1 : (m == 2'b10) ? f : 1'b0;
  endfunction

  task automatic cpuWrite(logic sel, logic [7:0] d);
    @(negedge clk); cpuSel = sel; cpuWr = 1; cpuWdata = d;
    @(negedge clk); cpuWr = 0;
    if (sel) mCtrl = d[7:2]; else begin mOut = d; mObf = 1; end
  endtask

  task automatic cpuRead(logic sel, output logic [7:0] d);
    @(negedge clk); cpuSel = sel; cpuRd = 1; #1 d = cpuRdata;
    @(negedge clk); cpuRd = 0; cpuSel = 1;
    if (!sel) mIbf = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    cpuSel = 1; #1;
    // R1 reset state
    check("R1 csr", cpuRdata, 8'h00);
    check("R1 pins", {flagAOut, flagAOe, flagBOut, flagBOe, pinOe}, {3'b0, 5'b01010});
    check("R1 pinOut", pinOut, 8'h00);

    // random register traffic, strobes idle
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 3);
      logic [7:0] v = 8'($urandom);
      case (op)
        0: cpuWrite(0, v);
        1: cpuWrite(1, v);
        2: begin cpuRead(1, r); check("R2 csr read", r, mCsr()); end
        default: begin cpuRead(0, r); check("R3 data read", r, mIn); end
      endcase
      #1;
      check("R7 flagA", {flagAOut, flagAOe},
            {flagVal(mCtrl[3:2], mObf), mCtrl[3:2] != 2'b11});
      check("R9 flagB", {flagBOut, flagBOe},
            {flagVal(mCtrl[5:4], mIbf), mCtrl[5:4] != 2'b11});
      check("R8 pinOut data", pinOut, mOut);
    end
    cpuRead(1, r); check("R2 flags ro", r, mCsr());
    cpuWrite(1, 8'h03); cpuRead(1, r);
    check("R2 bits 1:0 not writable", r[1:0], {mObf, 1'b0} & 2'b11 | {mObf, mIbf});

    // R4 edge capture
    cpuWrite(1, 8'h00);
    cpuRead(0, r);
    pinIn = 8'hA5; inStbN = 0; settle();
    cpuRead(1, r); check("R4 ibf set", r[0], 1'b1);
    pinIn = 8'h3C; settle();
    inStbN = 1; settle();
    cpuRead(0, r); check("R4 edge data", r, 8'hA5);
    cpuRead(1, r); check("R3 ibf cleared by read", r[0], 1'b0);

    // R5 level follow
    cpuWrite(1, 8'h04);
    pinIn = 8'h11; inStbN = 0; settle();
    pinIn = 8'h22; settle();
    inStbN = 1; settle();
    pinIn = 8'h33; settle();
    cpuRead(1, r); check("R5 ibf set", r[0], 1'b1);
    cpuRead(0, r); check("R5 level hold", r, 8'h22);

    // R6 falling edge clear
    cpuWrite(1, 8'h00);
    cpuWrite(0, 8'h5A); #1;
    check("R8 pinOut buffer", pinOut, 8'h5A);
    check("R11 oe idle", pinOe, 1'b0);
    outStbN = 0; settle();
    check("R11 oe active", pinOe, 1'b1);
    cpuRead(1, r); check("R6 falling clears", r[1], 1'b0);
    outStbN = 1; settle();
    check("R11 oe released", pinOe, 1'b0);
    // R6 rising edge clear
    cpuWrite(1, 8'h08); cpuWrite(0, 8'h77);
    outStbN = 0; settle();
    cpuRead(1, r); check("R6 falling ignored", r[1], 1'b1);
    outStbN = 1; settle();
    cpuRead(1, r); check("R6 rising clears", r[1], 1'b0);

    // R7 flag A showing obf
    cpuWrite(1, 8'h20); #1;
    check("R7 flagA obf low", flagAOut, 1'b0);
    cpuWrite(0, 8'h66); #1;
    check("R7 flagA obf high", flagAOut, 1'b1);

    // R8 select input
    cpuWrite(1, 8'h30);
    flagAIn = 1; settle();
    check("R8 pinOut csr", pinOut, 8'h32);
    check("R7 flagA input oe", flagAOe, 1'b0);
    flagAIn = 0; settle();
    check("R8 pinOut data back", pinOut, 8'h66);

    // R9 flag B showing ibf
    cpuWrite(1, 8'h80); #1;
    check("R9 flagB ibf low", flagBOut, 1'b0);
    pinIn = 8'h9C; inStbN = 0; settle(); inStbN = 1; settle();
    check("R9 flagB ibf high", flagBOut, 1'b1);
    cpuRead(0, r); check("R4 captured 9C", r, 8'h9C);

    // R10 port enable gate
    cpuWrite(1, 8'hC0);
    flagBIn = 1; settle();
    pinIn = 8'hE1; inStbN = 0; settle(); inStbN = 1; settle();
    cpuRead(1, r); check("R10 no ibf when disabled", r[0], 1'b0);
    cpuRead(0, r); check("R10 no capture when disabled", r, 8'h9C);
    cpuWrite(0, 8'h44);
    outStbN = 0; settle();
    check("R10 oe gated", pinOe, 1'b0);
    cpuRead(1, r); check("R10 obf kept", r[1], 1'b1);
    outStbN = 1; settle();
    flagBIn = 0; settle();
    pinIn = 8'hE2; inStbN = 0; settle(); inStbN = 1; settle();
    cpuRead(0, r); check("R10 capture enabled", r, 8'hE2);
    outStbN = 0; settle();
    check("R10 oe enabled", pinOe, 1'b1);
    cpuRead(1, r); check("R10 obf cleared", r[1], 1'b0);
    outStbN = 1; settle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule